// File: doc/BRIEF.md
# Clamped Complementary PWM Generator

This block produces a pulse-width modulated waveform whose period and high time are set at run time by two small unsigned control words. The controls are treated as static levels and are used directly, with no register interface. Before any value reaches the counter or the comparator, a conditioning stage makes it safe. A period below a fixed floor is raised to that floor, and the duty value is held at or below the resulting period. The output therefore can never run faster than the floor allows, and no compare can fall outside the count range.

A single up-counter advances once per clock while the block is enabled. It returns to zero after the last count of the effective period. A compare of the counter against the effective duty gives the raw waveform. A polarity control can flip that waveform. A second output always carries the logical opposite of the first. Dropping the enable forces both outputs low within the same cycle, whatever the polarity setting. It also parks the counter at zero, so the next enable starts at the beginning of a period.

Top module: `cpwm_top`

## Requirements
- R1: A period control value below 3 produces an output period of exactly 3 clock cycles.
- R2: A period control value P of 3 or more makes the waveform repeat every P clock cycles.
- R3: In each period, the non-inverted primary output is high for the first min(D, effective period) cycles and low for the rest. D is the duty control value. The first cycle after enable goes high counts as cycle 0 of a period.
- R4: A duty control value of 0 keeps the non-inverted primary output low for as long as the block is enabled.
- R5: A duty control value equal to or above the effective period keeps the non-inverted primary output high for as long as the block is enabled.
- R6: With the invert control at 1 and the block enabled, the primary output is the inverse of the waveform it would show with invert at 0.
- R7: While enabled, the complementary output is always the logical inverse of the primary output.
- R8: While enable is 0, both outputs are 0 in the same cycle, for either value of invert.
- R9: While the active-low reset is 0, the counter is held at 0. After reset is released with enable at 1, the waveform starts at cycle 0 of a period.
- R10: After enable has been 0 for at least one clock edge, setting enable to 1 again restarts the waveform at cycle 0 of a period.
- R11: If the period control is lowered at run time below the current count, the counter returns to 0 on the next clock edge. From then on the waveform follows the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the counter |
| enable | input | 1 | Run control. At 0, both outputs are 0 and the counter is parked |
| invert | input | 1 | Polarity control. At 1, the primary waveform is flipped |
| period_in | input | W (4) | Requested period in clock cycles, raised to at least 3 |
| duty_in | input | W (4) | Requested high time in clock cycles, limited to the period |
| pwm_out | output | 1 | Primary PWM output |
| pwm_comp_out | output | 1 | Complementary PWM output |

## Verification
The hardest case to reach is a counter that sits above the newly applied period. The counter is only visible through the output, and in normal running it never exceeds the effective period. To get there, the stimulus runs at the longest period with full duty for ten cycles. It then lowers the period control to 5 between two edges. The expected output is low in the cycle where the stale count exceeds the new duty limit, and high again one edge later when the counter has wrapped. Every combination of period, duty and polarity is also swept, and each one is entered through a disabled cycle so that the restart point is known.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   // Polarity selection applied after the compare stage
   typedef enum logic {
      POL_NORMAL = 1'b0,
      POL_INVERT = 1'b1
   } cpwm_pol_e;

   // Raise a value to a floor
   function automatic int unsigned floor_to(input int unsigned v, input int unsigned lo);
      return (v < lo) ? lo : v;
   endfunction

   // Limit a value to a ceiling
   function automatic int unsigned ceil_to(input int unsigned v, input int unsigned hi);
      return (v > hi) ? hi : v;
   endfunction

endpackage

// File: rtl/cpwm_cond.sv
// Input conditioning: floor on the period, ceiling on the duty
module cpwm_cond #(
   parameter int unsigned W       = 4,
   parameter int unsigned MIN_PER = 3
) (
   input  logic [W-1:0] raw_per,
   input  logic [W-1:0] raw_duty,
   output logic [W-1:0] eff_per,
   output logic [W-1:0] eff_duty
);
   localparam logic [W-1:0] FLOOR = W'(MIN_PER);

   generate
      if (MIN_PER > 1) begin : g_floor
         always_comb begin
            eff_per = (raw_per < FLOOR) ? FLOOR : raw_per;
         end
      end else begin : g_floor_one
         // A floor of one only has to replace a zero request
         always_comb begin
            eff_per = (raw_per == '0) ? W'(1) : raw_per;
         end
      end
   endgenerate

   always_comb begin
      eff_duty = (raw_duty > eff_per) ? eff_per : raw_duty;
   end
endmodule

// File: rtl/cpwm_cnt.sv
// Period counter: runs 0 .. eff_per-1, parked at 0 while not running
module cpwm_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] eff_per,
   output logic [W-1:0] cnt_q
);
   logic [W-1:0] last;
   logic         wrap;

   always_comb begin
      last = eff_per - W'(1);
      // ">=" also catches a count left above a period that just shrank
      wrap = (cnt_q >= last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + W'(1);
      end
   end
endmodule

// File: rtl/cpwm_drive.sv
// Compare stage, polarity and enable gating
module cpwm_drive
   import cpwm_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic         run,
   input  cpwm_pol_e    pol,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] eff_duty,
   output logic         pwm,
   output logic         pwm_n
);
   logic raw;
   logic shaped;

   always_comb begin
      raw = (cnt < eff_duty);
      unique case (pol)
         POL_INVERT: shaped = ~raw;
         default:    shaped = raw;
      endcase
      pwm   = run & shaped;
      pwm_n = run & ~shaped;
   end
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
   import cpwm_pkg::*;
#(
   parameter int unsigned W       = 4,
   parameter int unsigned MIN_PER = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         invert,
   input  logic [W-1:0] period_in,
   input  logic [W-1:0] duty_in,
   output logic         pwm_out,
   output logic         pwm_comp_out
);
   localparam int unsigned MAX_PER = (1 << W) - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("cpwm_top: W must be at least 2");
      end
      if (MIN_PER < 1 || MIN_PER > MAX_PER) begin : g_bad_floor
         $error("cpwm_top: MIN_PER must lie in 1 .. 2**W-1");
      end
   endgenerate

   logic [W-1:0] eff_per;
   logic [W-1:0] eff_duty;
   logic [W-1:0] cnt_q;
   cpwm_pol_e    pol;

   assign pol = invert ? POL_INVERT : POL_NORMAL;

   cpwm_cond #(.W(W), .MIN_PER(MIN_PER)) u_cond (
      .raw_per (period_in),
      .raw_duty(duty_in),
      .eff_per (eff_per),
      .eff_duty(eff_duty)
   );

   cpwm_cnt #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (enable),
      .eff_per(eff_per),
      .cnt_q  (cnt_q)
   );

   cpwm_drive #(.W(W)) u_drive (
      .run     (enable),
      .pol     (pol),
      .cnt     (cnt_q),
      .eff_duty(eff_duty),
      .pwm     (pwm_out),
      .pwm_n   (pwm_comp_out)
   );
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
   parameter int unsigned W       = 4,
   parameter int unsigned MIN_PER = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         enable,
   input logic         invert,
   input logic         pwm,
   input logic         pwm_n,
   input logic [W-1:0] cnt,
   input logic [W-1:0] eff_per,
   input logic [W-1:0] eff_duty
);
   assert_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      eff_per >= W'(MIN_PER));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (cnt < W'(eff_per - W'(1)))) |=> (cnt == W'($past(cnt) + W'(1))));

   assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eff_duty <= eff_per);

   assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && eff_duty == '0) |-> (pwm == invert));

   assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && eff_duty == eff_per && cnt < eff_per) |-> (pwm != invert));

   assert_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (pwm != pwm_n));

   assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!pwm && !pwm_n));

   assert_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt == '0));

   assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= W'(eff_per - W'(1))) |=> (cnt == '0));
endmodule

bind cpwm_top cpwm_checker #(.W(W), .MIN_PER(MIN_PER)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .enable  (enable),
   .invert  (invert),
   .pwm     (pwm_out),
   .pwm_n   (pwm_comp_out),
   .cnt     (cnt_q),
   .eff_per (eff_per),
   .eff_duty(eff_duty)
);

// File: tb/cpwm_top_test.sv
module cpwm_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int WATCHDOG   = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic         invert = 1'b0;
   logic [W-1:0] period_in = '0;
   logic [W-1:0] duty_in = '0;
   logic         pwm_out;
   logic         pwm_comp_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpwm_top #(.W(W), .MIN_PER(3)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .invert      (invert),
      .period_in   (period_in),
      .duty_in     (duty_in),
      .pwm_out     (pwm_out),
      .pwm_comp_out(pwm_comp_out)
   );

   function automatic int eff_p(input int p);
      return (p < 3) ? 3 : p;
   endfunction

   function automatic int eff_d(input int p, input int d);
      return (d > eff_p(p)) ? eff_p(p) : d;
   endfunction

   // Expected primary level at cycle k of a run started at count 0
   function automatic logic exp_pwm(input int p, input int d, input int inv, input int k);
      logic raw;
      raw = ((k % eff_p(p)) < eff_d(p, d));
      return raw ^ logic'(inv);
   endfunction

   task automatic check(input string req, input logic act_p, input logic act_n,
                        input logic exp_p, input logic exp_n);
      checks++;
      if (act_p !== exp_p || act_n !== exp_n) begin
         fails++;
         $display("FAIL %s: pwm/comp actual %b/%b expected %b/%b at %0t",
                  req, act_p, act_n, exp_p, exp_n, $time);
      end
   endtask

   // Sample point: one time unit after the falling edge where inputs change
   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      // R9: reset holds counter at 0; with P=4 D=2 the output shows count 0
      enable = 1'b1; period_in = 4'd4; duty_in = 4'd2; invert = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step(); #1;
         check("R9", pwm_out, pwm_comp_out, 1'b1, 1'b0);
      end
      step(); rst_n = 1'b1; #1;
      for (int k = 0; k < 9; k++) begin
         if (k > 0) begin step(); #1; end
         check("R9", pwm_out, pwm_comp_out, exp_pwm(4, 2, 0, k), ~exp_pwm(4, 2, 0, k));
      end

      // Sweep every period, duty and polarity, each entered through a disabled cycle
      for (int inv = 0; inv < 2; inv++) begin
         for (int p = 0; p < 16; p++) begin
            for (int d = 0; d < 16; d++) begin
               string rq;
               step(); enable = 1'b0; invert = logic'(inv);
               period_in = W'(p); duty_in = W'(d); #1;
               check("R8", pwm_out, pwm_comp_out, 1'b0, 1'b0);
               step(); enable = 1'b1; #1;
               if (p < 3)                 rq = "R1";
               else if (d == 0)           rq = "R4";
               else if (d >= eff_p(p))    rq = "R5";
               else if (inv == 1)         rq = "R6";
               else                       rq = "R3";
               for (int k = 0; k < 2 * eff_p(p) + 1; k++) begin
                  logic e;
                  if (k > 0) begin step(); #1; end
                  e = exp_pwm(p, d, inv, k);
                  // R2 R7 R10: period repeat, complement, restart at cycle 0
                  check(rq, pwm_out, pwm_comp_out, e, ~e);
               end
            end
         end
      end

      // R11: lower the period below a running count
      step(); enable = 1'b0; invert = 1'b0; period_in = 4'd15; duty_in = 4'd15;
      step(); enable = 1'b1;
      for (int k = 0; k < 10; k++) step();
      period_in = 4'd5; #1;
      // count 10, new duty limit 5 -> low
      check("R11", pwm_out, pwm_comp_out, 1'b0, 1'b1);
      for (int k = 0; k < 11; k++) begin
         logic e;
         step(); #1;
         e = exp_pwm(5, 15, 0, k);
         check("R11", pwm_out, pwm_comp_out, e, ~e);
      end

      // R8 with invert high in the middle of a run
      step(); invert = 1'b1; period_in = 4'd7; duty_in = 4'd3;
      step(); step(); enable = 1'b0; #1;
      check("R8", pwm_out, pwm_comp_out, 1'b0, 1'b0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule